// File: doc/BRIEF.md
# Double-Buffered Master SPI Engine

This block is a master-only serial peripheral engine. It drives the serial clock itself and exchanges one 8-bit frame per transfer, full duplex: every frame shifts a byte out on `mosi` and captures a byte from `miso`. The serial clock is derived from the system clock through a programmable 12-bit divisor. The clock polarity, the clock phase and the bit order are set by configuration inputs.

Software places a byte in a one-entry transmit holding buffer. When the shifter is free, and at the end of every frame, a waiting byte moves into the shifter, so queued bytes go out back to back with no idle clock between frames. A receive buffer keeps the last received byte. Four status flags report:

- the holding buffer is empty,
- the transfer is complete,
- a byte was received,
- a receive overrun occurred.

Each flag has an interrupt enable, and the enabled flags are combined onto one interrupt line.

The controller is a state machine with three named states:

- `ST_IDLE`: no frame is running.
- `ST_LEAD`: the engine waits for the leading clock edge of the current bit.
- `ST_TRAIL`: the engine waits for the trailing clock edge of the current bit.

It has five transitions:

- *start* (`ST_IDLE`→`ST_LEAD`): transmit is enabled and the holding buffer is full.
- *lead edge* (`ST_LEAD`→`ST_TRAIL`): a baud tick occurs.
- *next bit* (`ST_TRAIL`→`ST_LEAD`): a baud tick occurs on any bit but the last.
- *reload* (`ST_TRAIL`→`ST_LEAD`): a baud tick occurs on the last bit while a byte is waiting and transmit is enabled.
- *finish* (`ST_TRAIL`→`ST_IDLE`): a baud tick occurs on the last bit with no byte to reload.

Top module: `spi_mst_engine`

## Requirements
- R1: The engine is master-only. `sck` changes only during a frame, and only on a baud tick. A tick occurs every `div`+1 system clocks, so each half period of `sck` is `div`+1 clocks and the serial rate is fclk/(2·(`div`+1)). With `div`=0, `sck` toggles on every clock.
- R2: `cpol` sets the level of `sck` between frames.
  - With `cpha`=0, the first data bit is on `mosi` before the first edge. `miso` is sampled on leading edges and `mosi` changes on trailing edges.
  - With `cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R3: With `lsb_first`=1, bit 0 is sent and received first. With `lsb_first`=0, bit 7 is first. The same order applies to `mosi` and to the assembly of `rx_data`.
- R4: Outside a frame, `sck` equals `cpol` and `mosi` holds the last bit it drove.
- R5: A write (`wr_valid`) is taken into the holding buffer only while `flag_dre`=1; a write while the buffer is full is ignored. A waiting byte is reloaded on the last edge of a frame, so every `sck` half period across the frame boundary is the same `div`+1 clocks.
- R6: Each frame sends the 8 bits of the shifted byte and receives 8 bits. `rx_data` takes the received byte at the end of the frame.
- R7: A frame starts only while `tx_en`=1. With `tx_en`=0, a written byte stays in the holding buffer, `sck` does not toggle and `flag_dre` stays 0.
- R8: With `rx_en`=0, a completed frame leaves `rx_data` and `flag_rxc` unchanged.
- R9: Flag behaviour:
  - `flag_dre` is 1 whenever the holding buffer is empty. It returns to 1 when the waiting byte moves into the shifter.
  - `flag_txc` is set when a frame ends with no byte to reload, and is cleared by `clr_txc`.
  - `flag_rxc` is set when a byte is written to `rx_data`, and is cleared by `rd_ack`.
  - When a set and a clear coincide, the set wins.
- R10: A received byte that arrives while `flag_rxc`=1 overwrites `rx_data` and sets `flag_ovr`. `flag_ovr` stays set until `clr_ovr`.
- R11: `irq` is the OR of the flags that are set and enabled. The bits of `irq_en` map as follows: [0] `flag_dre`, [1] `flag_txc`, [2] `flag_rxc`, [3] `flag_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; frames start only when high |
| rx_en | input | 1 | Receiver enable; received bytes are stored only when high |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| div | input | 12 | Baud divisor; half period is div+1 clocks |
| wr_valid | input | 1 | One-cycle write strobe for the holding buffer |
| wr_data | input | 8 | Byte to queue for transmit |
| rd_ack | input | 1 | Acknowledges the received byte; clears flag_rxc |
| clr_txc | input | 1 | Clears flag_txc |
| clr_ovr | input | 1 | Clears flag_ovr |
| irq_en | input | 4 | Per-flag interrupt enables |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| rx_data | output | 8 | Last received byte |
| flag_dre | output | 1 | Holding buffer empty |
| flag_txc | output | 1 | Transfer complete |
| flag_rxc | output | 1 | Receive complete |
| flag_ovr | output | 1 | Sticky receive overrun |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a slave model that records every `sck` edge and its distance in clocks from the previous edge. This exposes a divisor that is off by one, and a reload that adds an idle half period between queued frames, because that gap breaks the uniform spacing. All four clock modes are run with both bit orders. A design that sampled on the wrong edge, or presented the first bit late in phase 0, returns shifted bytes on both `mosi` and `rx_data`. Further directed cases check that:
- a write to a full holding buffer is ignored, which catches a design that lets the second write replace the first;
- a disabled transmitter holds its byte;
- a disabled receiver leaves the receive buffer untouched;
- a second unread byte sets the sticky overrun, which catches a design that drops the new byte or never sets the flag.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_state_e;

    localparam int FLAG_DRE  = 0;
    localparam int FLAG_TXC  = 1;
    localparam int FLAG_RXC  = 2;
    localparam int FLAG_OVR  = 3;
    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // Counter restarts whenever the engine idles or a tick fires, so ticks
    // stay evenly spaced across a reload.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              miso,
    output logic              sck_phase,
    output logic              mosi,
    output logic              busy,
    output logic              load,
    output logic              rx_load,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done_empty
);

    localparam int                BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);

    xfer_state_e       state_q, next_state;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_next;
    logic              mosi_q;

    logic              start;
    logic              last_bit;
    logic              frame_end;
    logic              reload;
    logic              sample_now;
    logic [BIT_W-1:0]  rx_pos;
    logic [BIT_W-1:0]  bit_inc;

    function automatic logic pick_bit(input logic [DATA_W-1:0] b,
                                      input logic [BIT_W-1:0]  k,
                                      input logic              lsb);
        return lsb ? b[k] : b[LAST_BIT - k];
    endfunction

    assign start      = (state_q == ST_IDLE) && tx_en && hold_full;
    assign last_bit   = (bit_q == LAST_BIT);
    assign frame_end  = (state_q == ST_TRAIL) && tick && last_bit;
    assign reload     = frame_end && tx_en && hold_full;
    assign load       = start || reload;
    assign sample_now = tick && (((state_q == ST_LEAD) && !cpha) ||
                                 ((state_q == ST_TRAIL) && cpha));
    assign rx_pos     = lsb_first ? bit_q : (LAST_BIT - bit_q);
    assign bit_inc    = bit_q + 1'b1;

    always_comb begin
        rx_next = rx_q;
        if (sample_now) begin
            rx_next[rx_pos] = miso;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= next_state;
        end
    end

    // Transitions: start, lead edge, next bit, reload, finish
    always_comb begin
        next_state = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) next_state = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) next_state = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (!last_bit)   next_state = ST_LEAD;
                    else if (reload) next_state = ST_LEAD;
                    else             next_state = ST_IDLE;
                end
            end
            default: next_state = ST_IDLE;
        endcase
    end

    // Output and datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            mosi_q <= 1'b0;
        end else begin
            if (sample_now) begin
                rx_q <= rx_next;
            end
            if (load) begin
                tx_q  <= hold_data;
                bit_q <= '0;
                if (!cpha) begin
                    mosi_q <= pick_bit(hold_data, '0, lsb_first);
                end
            end else if (tick) begin
                unique case (state_q)
                    ST_LEAD: begin
                        if (cpha) begin
                            mosi_q <= pick_bit(tx_q, bit_q, lsb_first);
                        end
                    end
                    ST_TRAIL: begin
                        bit_q <= bit_inc;
                        if (!cpha && !last_bit) begin
                            mosi_q <= pick_bit(tx_q, bit_inc, lsb_first);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sck_phase  = (state_q == ST_TRAIL);
    assign busy       = (state_q != ST_IDLE);
    assign mosi       = mosi_q;
    assign rx_load    = frame_end && rx_en;
    assign rx_byte    = rx_next;
    assign done_empty = frame_end && !reload;

endmodule

// File: rtl/spi_buf_flags.sv
module spi_buf_flags
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 load,
    input  logic                 rx_load,
    input  logic [DATA_W-1:0]    rx_byte,
    input  logic                 done_empty,
    input  logic                 rd_ack,
    input  logic                 clr_txc,
    input  logic                 clr_ovr,
    input  logic [NUM_FLAGS-1:0] ie,
    output logic                 hold_full,
    output logic [DATA_W-1:0]    hold_data,
    output logic [DATA_W-1:0]    rx_data,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);

    logic                 txc_q, rxc_q, ovr_q;
    logic [NUM_FLAGS-1:0] masked;

    // Holding buffer: a write lands only when empty; a load always empties it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (load) begin
            hold_full <= 1'b0;
        end else if (wr_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    // Receive buffer and completion flags; a set wins over a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            txc_q   <= 1'b0;
            rxc_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (rx_load) begin
                rx_data <= rx_byte;
            end

            if (done_empty)   txc_q <= 1'b1;
            else if (clr_txc) txc_q <= 1'b0;

            if (rx_load)     rxc_q <= 1'b1;
            else if (rd_ack) rxc_q <= 1'b0;

            if (rx_load && rxc_q) ovr_q <= 1'b1;
            else if (clr_ovr)     ovr_q <= 1'b0;
        end
    end

    always_comb begin
        flags           = '0;
        flags[FLAG_DRE] = !hold_full;
        flags[FLAG_TXC] = txc_q;
        flags[FLAG_RXC] = rxc_q;
        flags[FLAG_OVR] = ovr_q;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_mask
        assign masked[g] = flags[g] & ie[g];
    end

    assign irq = |masked;

endmodule

// File: rtl/spi_mst_engine.sv
module spi_mst_engine
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 cpol,
    input  logic                 cpha,
    input  logic                 lsb_first,
    input  logic [DIV_W-1:0]     div,
    input  logic                 wr_valid,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_ack,
    input  logic                 clr_txc,
    input  logic                 clr_ovr,
    input  logic [NUM_FLAGS-1:0] irq_en,
    input  logic                 miso,
    output logic                 sck,
    output logic                 mosi,
    output logic [DATA_W-1:0]    rx_data,
    output logic                 flag_dre,
    output logic                 flag_txc,
    output logic                 flag_rxc,
    output logic                 flag_ovr,
    output logic                 irq
);

    logic                 baud_tick;
    logic                 busy;
    logic                 sck_phase;
    logic                 load;
    logic                 rx_load;
    logic                 done_empty;
    logic                 hold_full;
    logic [DATA_W-1:0]    hold_data;
    logic [DATA_W-1:0]    rx_byte;
    logic [NUM_FLAGS-1:0] flags;

    spi_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .tick  (baud_tick)
    );

    spi_xfer_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .tx_en      (tx_en),
        .rx_en      (rx_en),
        .cpha       (cpha),
        .lsb_first  (lsb_first),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .miso       (miso),
        .sck_phase  (sck_phase),
        .mosi       (mosi),
        .busy       (busy),
        .load       (load),
        .rx_load    (rx_load),
        .rx_byte    (rx_byte),
        .done_empty (done_empty)
    );

    spi_buf_flags #(.DATA_W(DATA_W)) bufs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .load       (load),
        .rx_load    (rx_load),
        .rx_byte    (rx_byte),
        .done_empty (done_empty),
        .rd_ack     (rd_ack),
        .clr_txc    (clr_txc),
        .clr_ovr    (clr_ovr),
        .ie         (irq_en),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .rx_data    (rx_data),
        .flags      (flags),
        .irq        (irq)
    );

    assign sck      = cpol ^ sck_phase;
    assign flag_dre = flags[FLAG_DRE];
    assign flag_txc = flags[FLAG_TXC];
    assign flag_rxc = flags[FLAG_RXC];
    assign flag_ovr = flags[FLAG_OVR];

endmodule

// File: rtl/spi_mst_checker.sv
module spi_mst_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpol,
    input logic              sck,
    input logic              mosi,
    input logic              busy,
    input logic              tick,
    input logic              load,
    input logic              rx_load,
    input logic              wr_valid,
    input logic [DATA_W-1:0] hold_data,
    input logic              flag_dre,
    input logic              flag_rxc,
    input logic              flag_ovr,
    input logic              clr_ovr,
    input logic [3:0]        ie,
    input logic              irq
);

    // R1: serial clock moves only as a result of a baud tick
    assert_sck_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck) && $stable(cpol)) |-> $past(tick));

    // R4: between frames the data line does not move
    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy && $past(!busy)) |-> $stable(mosi));

    // R5: a write into a full holding buffer leaves it untouched
    assert_full_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !flag_dre && !load) |=> $stable(hold_data));

    // R10: a new byte on top of an unread one raises overrun
    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && flag_rxc) |=> flag_ovr);

    // R10: overrun is sticky until its clear
    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovr && !clr_ovr) |=> flag_ovr);

    // R11: an enabled receive flag drives the interrupt
    assert_irq_rxc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rxc && ie[2]) |-> irq);

endmodule

bind spi_mst_engine spi_mst_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpol      (cpol),
    .sck       (sck),
    .mosi      (mosi),
    .busy      (busy),
    .tick      (baud_tick),
    .load      (load),
    .rx_load   (rx_load),
    .wr_valid  (wr_valid),
    .hold_data (hold_data),
    .flag_dre  (flag_dre),
    .flag_rxc  (flag_rxc),
    .flag_ovr  (flag_ovr),
    .clr_ovr   (clr_ovr),
    .ie        (irq_en),
    .irq       (irq)
);

// File: tb/spi_mst_engine_tb_top.sv
`timescale 1ns/1ps
module spi_mst_engine_tb_top;

    localparam real CLK_P = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic [11:0] div = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_ack = 1'b0, clr_txc = 1'b0, clr_ovr = 1'b0;
    logic [3:0]  ie = '0;
    logic        miso = 1'b0;
    logic        sck, mosi, flag_dre, flag_txc, flag_rxc, flag_ovr, irq;
    logic [7:0]  rx_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // slave model state
    logic [7:0] s_tab [0:3];
    logic [7:0] m_got [0:3];
    logic [7:0] m_cur, s_cur;
    logic       sck_prev;
    int         ec, fidx, cyc, last_edge, gap_err, exp_gap;
    bit         edge_valid;

    always #(CLK_P/2) clk = ~clk;

    spi_mst_engine dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .cpol(cpol),
        .cpha(cpha), .lsb_first(lsb), .div(div), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_ack(rd_ack), .clr_txc(clr_txc), .clr_ovr(clr_ovr),
        .irq_en(ie), .miso(miso), .sck(sck), .mosi(mosi), .rx_data(rx_data),
        .flag_dre(flag_dre), .flag_txc(flag_txc), .flag_rxc(flag_rxc),
        .flag_ovr(flag_ovr), .irq(irq)
    );

    function automatic int f_pos(int k, bit l);
        return l ? k : 7 - k;
    endfunction

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n && sck !== sck_prev) begin
            if (edge_valid && (cyc - last_edge) != exp_gap) gap_err++;
            last_edge  = cyc;
            edge_valid = 1;
            if (ec[0] == cpha) begin
                m_cur[f_pos(ec / 2, lsb)] = mosi;
            end else begin
                int k;
                k = cpha ? ec / 2 : (ec + 1) / 2;
                if (k < 8) miso = s_cur[f_pos(k, lsb)];
            end
            if (ec == 15) begin
                m_got[fidx % 4] = m_cur;
                fidx++;
                s_cur = s_tab[fidx % 4];
                ec = 0;
                if (!cpha) miso = s_cur[f_pos(0, lsb)];
            end else begin
                ec++;
            end
        end
        sck_prev = sck;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int mode, input bit l, input int d,
                       input bit te, input bit re);
        @(posedge clk); #1;
        cpol = mode[1]; cpha = mode[0]; lsb = l; div = 12'(d);
        tx_en = te; rx_en = re;
        #1;
        exp_gap = d + 1; ec = 0; fidx = 0; edge_valid = 0; gap_err = 0;
        sck_prev = sck; s_cur = s_tab[0];
        miso = cpha ? 1'b0 : s_cur[f_pos(0, l)];
    endtask

    task automatic write_tx(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); rd_ack = 1'b1; clr_txc = 1'b1; clr_ovr = 1'b1;
        @(negedge clk); rd_ack = 1'b0; clr_txc = 1'b0; clr_ovr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!flag_txc && n < 5000) begin
            @(negedge clk); n++;
        end
        @(negedge clk);
        chk(n < 5000, req, "frame completion", n, 0);
    endtask

    task automatic t_reset();
        chk(sck == 1'b0, "R4", "reset sck", sck, 0);
        chk(flag_dre == 1'b1, "R9", "reset dre", flag_dre, 1);
        chk({flag_txc, flag_rxc, flag_ovr} == 3'b000, "R9", "reset flags",
            {flag_txc, flag_rxc, flag_ovr}, 0);
        chk(irq == 1'b0, "R11", "reset irq", irq, 0);
    endtask

    task automatic run_single(input int mode, input bit l, input int d,
                              input logic [7:0] tx, input logic [7:0] sx);
        logic m0;
        clear_all();
        s_tab[0] = sx; s_tab[1] = 8'h00;
        cfg(mode, l, d, 1'b1, 1'b1);
        write_tx(tx);
        wait_done("R6");
        chk(m_got[0] == tx, "R2/R3", "mosi byte", m_got[0], tx);
        chk(rx_data == sx, "R6", "rx byte", rx_data, sx);
        chk(gap_err == 0, "R1", "sck half period spacing", gap_err, 0);
        chk(flag_rxc == 1'b1, "R9", "rxc set", flag_rxc, 1);
        chk(sck == cpol, "R4", "idle sck level", sck, cpol);
        chk(mosi == tx[f_pos(7, l)], "R4", "mosi holds last bit", mosi, tx[f_pos(7, l)]);
        m0 = mosi;
        repeat (5) @(negedge clk);
        chk(mosi == m0, "R4", "mosi stable when idle", mosi, m0);
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        chk(flag_rxc == 1'b0, "R9", "rxc cleared by rd_ack", flag_rxc, 0);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 2; l++) begin
                logic [7:0] tx, sx;
                tx = 8'(8'h1D + m * 53 + l * 97);
                sx = ~tx ^ 8'h6B;
                run_single(m, l[0], 1 + m % 2, tx, sx);
            end
        end
        run_single(3, 1'b1, 0, 8'hC4, 8'h39);   // R1 fastest rate
    endtask

    task automatic t_back_to_back();
        int n = 0;
        clear_all();
        s_tab[0] = 8'hE1; s_tab[1] = 8'h2B; s_tab[2] = 8'h00;
        ie = 4'b1000;
        cfg(1, 1'b0, 3, 1'b1, 1'b1);
        write_tx(8'h96);
        while (!flag_dre && n < 100) begin @(negedge clk); n++; end
        write_tx(8'h5E);
        chk(flag_dre == 1'b0, "R5", "second byte queued", flag_dre, 0);
        wait_done("R5");
        chk(fidx == 2, "R5", "two frames ran", fidx, 2);
        chk(m_got[0] == 8'h96 && m_got[1] == 8'h5E, "R5", "queued bytes in order",
            {m_got[0], m_got[1]}, 16'h965E);
        chk(gap_err == 0, "R5", "no gap at frame boundary", gap_err, 0);
        chk(flag_ovr == 1'b1, "R10", "overrun set", flag_ovr, 1);
        chk(rx_data == 8'h2B, "R10", "rx overwritten", rx_data, 8'h2B);
        chk(irq == 1'b1, "R11", "irq from overrun", irq, 1);
        repeat (3) @(negedge clk);
        chk(flag_ovr == 1'b1, "R10", "overrun sticky", flag_ovr, 1);
        @(negedge clk); clr_ovr = 1'b1;
        @(negedge clk); clr_ovr = 1'b0;
        chk(flag_ovr == 1'b0, "R10", "overrun cleared", flag_ovr, 0);
        chk(irq == 1'b0, "R11", "irq drops with flag", irq, 0);
        ie = 4'b0000;
    endtask

    task automatic t_rx_off();
        logic [7:0] keep;
        clear_all();
        keep = rx_data;
        s_tab[0] = ~keep;
        cfg(0, 1'b0, 1, 1'b1, 1'b0);
        write_tx(8'h73);
        wait_done("R8");
        chk(m_got[0] == 8'h73, "R8", "tx runs with rx off", m_got[0], 8'h73);
        chk(rx_data == keep, "R8", "rx_data unchanged", rx_data, keep);
        chk(flag_rxc == 1'b0, "R8", "rxc not set", flag_rxc, 0);
    endtask

    task automatic t_tx_gate();
        clear_all();
        s_tab[0] = 8'h44;
        cfg(2, 1'b1, 2, 1'b0, 1'b1);
        write_tx(8'hA9);
        write_tx(8'h17);
        repeat (30) @(negedge clk);
        chk(ec == 0 && fidx == 0, "R7", "no clock while tx disabled", ec, 0);
        chk(flag_dre == 1'b0, "R7", "byte held in buffer", flag_dre, 0);
        @(negedge clk); tx_en = 1'b1;
        wait_done("R7");
        chk(m_got[0] == 8'hA9, "R5", "write to full buffer ignored", m_got[0], 8'hA9);
        chk(fidx == 1, "R5", "only one frame sent", fidx, 1);
    endtask

    task automatic t_irq();
        clear_all();
        ie = 4'b0010;
        cfg(0, 1'b0, 0, 1'b1, 1'b1);
        write_tx(8'h3A);
        wait_done("R11");
        chk(irq == 1'b1, "R11", "irq from txc", irq, 1);
        ie = 4'b0000;
        @(negedge clk);
        chk(irq == 1'b0, "R11", "irq masked", irq, 0);
        @(negedge clk); clr_txc = 1'b1;
        @(negedge clk); clr_txc = 1'b0;
        chk(flag_txc == 1'b0, "R9", "txc cleared", flag_txc, 0);
        ie = 4'b0001;
        @(negedge clk);
        chk(irq == 1'b1, "R11", "irq from dre", irq, 1);
        ie = 4'b0000;
    endtask

    initial begin
        s_tab[0] = 8'h00; s_tab[1] = 8'h00; s_tab[2] = 8'h00; s_tab[3] = 8'h00;
        m_got[0] = 8'h00; m_got[1] = 8'h00; m_got[2] = 8'h00; m_got[3] = 8'h00;
        sck_prev = 1'b0; ec = 0; fidx = 0; cyc = 0; gap_err = 0; exp_gap = 1;
        edge_valid = 0; last_edge = 0; m_cur = 8'h00; s_cur = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_back_to_back();
        t_rx_off();
        t_tx_gate();
        t_irq();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule